// File: doc/BRIEF.md
# Pointer-Walk Huffman Symbol Decoder

This block turns a serial stream of code bits into 8-bit characters. The code tree sits in an on-chip node memory as tagged nodes. Each node is either a leaf that holds a character or a branch that holds two child pointers. Decoding walks those pointers one bit at a time. It does not look anything up in a code table.

Before decoding, a host loads the tree through a single-cycle write port. The host then pulses `go`. Code bits arrive on a valid/ready stream, and a separate flag on that stream marks its end. Decoded characters leave on a valid/ready output stream. A one-cycle `done` pulse shows that the end marker was taken. The decoder then goes back to idle, and the host may load a new tree and start again.

Top module: `htree_walk_decoder`

## Requirements
- R1: A node is 19 bits. Bit 18 is the tag: 1 marks a leaf, whose character sits in bits [7:0]. A tag of 0 marks a branch, with the left child pointer in bits [17:9] and the right child pointer in bits [8:0]. A write on the host port stores `wr_data` at `wr_addr`.
- R2: The decoder stays idle after reset with `in_ready` and `out_valid` low. A `go` pulse starts a walk at the root, which is address 0.
- R3: While the current node is a branch, the block accepts one input beat. Code bit 0 moves the walk to the left child and code bit 1 moves it to the right child. A node fetch takes one cycle of read latency.
- R4: On reaching a leaf, the block presents the leaf's character on `out_char` with `out_valid` high and restarts at the root. It consumes no input bit for this step, so the output equals the sequence of characters whose codes were sent.
- R5: An input beat with `in_eos` = 1 carries no code bit. When it is accepted, `done` is high for exactly one cycle, no further character is produced, and the block returns to idle.
- R6: While `out_valid` is high and `out_ready` is low, `out_char` holds its value and `in_ready` stays low. The walk waits until the character is taken.
- R7: If the stream ends partway through a code, the partial code yields no character and `done` is still raised.
- R8: After reset, `out_valid`, `done` and `in_ready` are 0.
- R9: After `done`, the tree may be rewritten and `go` pulsed again. The next stream is then decoded with the new tree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Node memory write strobe |
| wr_addr | input | 9 | Node address to write |
| wr_data | input | 19 | Node value to write |
| go | input | 1 | Start decoding a new stream at the root |
| in_valid | input | 1 | Input beat present |
| in_bit | input | 1 | Code bit of the beat |
| in_eos | input | 1 | Beat marks end of stream |
| in_ready | output | 1 | Decoder can take an input beat |
| out_valid | output | 1 | Decoded character present |
| out_char | output | 8 | Decoded character |
| out_ready | input | 1 | Consumer takes the character |
| done | output | 1 | One-cycle pulse when the end marker is accepted |

## Verification
The assertions assume the tree is well formed. Every branch pointer must name a node that has been written, no cycle may exist, the root must be a branch, and no write may happen while a stream is being decoded. The bench builds each tree by repeatedly splitting a randomly chosen leaf into two new leaves, which keeps every pointer valid and free of cycles. It finishes all writes before pulsing `go`. Input gaps and output stalls are random, with one directed run that holds `out_ready` low for several cycles on each character.

// File: rtl/htd_pkg.sv
package htd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_EVAL,
    S_BIT,
    S_EMIT
  } walk_state_t;
endpackage

// File: rtl/htd_node_ram.sv
module htd_node_ram #(
  parameter int AW = 9,
  parameter int DW = 19
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/htd_walker.sv
module htd_walker
  import htd_pkg::*;
#(
  parameter int PTR_W  = 9,
  parameter int CHAR_W = 8,
  parameter int NODE_W = 1 + 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              rd_en,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [NODE_W-1:0] node,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              in_eos,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  input  logic              out_ready,
  output logic              done
);
  localparam logic [PTR_W-1:0] ROOT = '0;

  walk_state_t      state;
  logic [PTR_W-1:0] cur;
  logic [PTR_W-1:0] left_r;
  logic [PTR_W-1:0] right_r;

  logic              node_is_leaf;
  logic [PTR_W-1:0]  node_left;
  logic [PTR_W-1:0]  node_right;
  logic [CHAR_W-1:0] node_char;

  assign node_is_leaf = node[NODE_W-1];
  assign node_left    = node[2*PTR_W-1:PTR_W];
  assign node_right   = node[PTR_W-1:0];
  assign node_char    = node[CHAR_W-1:0];

  assign rd_en    = (state == S_FETCH);
  assign rd_addr  = cur;
  assign in_ready = (state == S_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur       <= ROOT;
      left_r    <= '0;
      right_r   <= '0;
      out_valid <= 1'b0;
      out_char  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (go) begin
            cur   <= ROOT;
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_EVAL;
        S_EVAL: begin
          if (node_is_leaf) begin
            out_char  <= node_char;
            out_valid <= 1'b1;
            cur       <= ROOT;
            state     <= S_EMIT;
          end else begin
            left_r  <= node_left;
            right_r <= node_right;
            state   <= S_BIT;
          end
        end
        S_BIT: begin
          if (in_valid) begin
            if (in_eos) begin
              done  <= 1'b1;
              cur   <= ROOT;
              state <= S_IDLE;
            end else begin
              cur   <= in_bit ? right_r : left_r;
              state <= S_FETCH;
            end
          end
        end
        S_EMIT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (!in_ready && !out_valid)); // R2

  AST_BIT_STEERS: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && !in_eos) |=>
      (rd_en && rd_addr == ($past(in_bit) ? $past(right_r) : $past(left_r)))); // R3

  AST_LEAF_TO_ROOT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (rd_en && rd_addr == ROOT)); // R4

  AST_EOS_DONE: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && in_eos) |=> (done && !out_valid)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char))); // R6

  AST_STALL_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R6
endmodule

// File: rtl/htree_walk_decoder.sv
module htree_walk_decoder #(
  parameter int PTR_W  = 9,
  parameter int CHAR_W = 8,
  parameter int NODE_W = 1 + 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [NODE_W-1:0] wr_data,
  input  logic              go,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              in_eos,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  input  logic              out_ready,
  output logic              done
);
  logic              rd_en;
  logic [PTR_W-1:0]  rd_addr;
  logic [NODE_W-1:0] rd_data;

  htd_node_ram #(.AW(PTR_W), .DW(NODE_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  htd_walker #(.PTR_W(PTR_W), .CHAR_W(CHAR_W), .NODE_W(NODE_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .node      (rd_data),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_eos    (in_eos),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_char  (out_char),
    .out_ready (out_ready),
    .done      (done)
  );
endmodule

// File: tb/htree_walk_decoder_bench.sv
module htree_walk_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [18:0] wr_data = '0;
  logic        go = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        in_eos = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_char;
  logic        out_ready = 1'b0;
  logic        done;

  always #5 clk = ~clk;

  htree_walk_decoder u_htree_walk_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go(go), .in_valid(in_valid), .in_bit(in_bit), .in_eos(in_eos),
    .in_ready(in_ready), .out_valid(out_valid), .out_char(out_char),
    .out_ready(out_ready), .done(done)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // bench-side tree model
  bit        is_leaf [64];
  int        lchild  [64];
  int        rchild  [64];
  int        parent  [64];
  bit        side    [64];
  int        depth   [64];
  logic [7:0] chr    [64];
  int        n_nodes;
  bit        sbits [$];
  logic [7:0] exp_q [$];
  int        stall_mode = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [18:0] enc(input int i);
    if (is_leaf[i]) return {1'b1, 10'd0, chr[i]};
    return {1'b0, lchild[i][8:0], rchild[i][8:0]};
  endfunction

  task automatic load_tree();
    for (int i = 0; i < n_nodes; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = i[8:0]; wr_data = enc(i);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic random_tree(input int splits, input logic [7:0] base);
    n_nodes = 1; is_leaf[0] = 1'b1; parent[0] = -1; depth[0] = 0; chr[0] = base;
    for (int s = 0; s < splits; s++) begin
      int idx;
      idx = $urandom % n_nodes;
      while (!is_leaf[idx] || depth[idx] >= 10) idx = $urandom % n_nodes;
      is_leaf[n_nodes] = 1'b1; chr[n_nodes] = chr[idx];
      parent[n_nodes] = idx; side[n_nodes] = 1'b0; depth[n_nodes] = depth[idx] + 1;
      is_leaf[n_nodes+1] = 1'b1; chr[n_nodes+1] = base + 8'(n_nodes + 1);
      parent[n_nodes+1] = idx; side[n_nodes+1] = 1'b1; depth[n_nodes+1] = depth[idx] + 1;
      is_leaf[idx] = 1'b0; lchild[idx] = n_nodes; rchild[idx] = n_nodes + 1;
      n_nodes += 2;
    end
  endtask

  task automatic push_code(input int leaf, input int keep);
    bit path [$];
    int x;
    x = leaf;
    while (parent[x] >= 0) begin
      path.push_front(side[x]);
      x = parent[x];
    end
    for (int i = 0; i < keep && i < path.size(); i++) sbits.push_back(path[i]);
  endtask

  task automatic make_stream(input int nsym, input bit partial);
    int leaves [$];
    sbits.delete(); exp_q.delete();
    for (int i = 0; i < n_nodes; i++) if (is_leaf[i]) leaves.push_back(i);
    for (int k = 0; k < nsym; k++) begin
      int lf;
      lf = leaves[$urandom % leaves.size()];
      push_code(lf, depth[lf]);
      exp_q.push_back(chr[lf]);
    end
    if (partial) begin
      int lf;
      lf = leaves[$urandom % leaves.size()];
      while (depth[lf] < 2) lf = leaves[$urandom % leaves.size()];
      push_code(lf, 1 + ($urandom % (depth[lf] - 1)));  // R7 partial code
    end
  endtask

  task automatic run_stream(input string tag);
    int ip = 0, op = 0, n_done = 0, wait_cnt = 0, guard = 0;
    bit eos_taken = 0, prev_hold = 0, rdy;
    logic [7:0] prev_char = '0;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    while (n_done == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (done) n_done++;
      if (prev_hold)
        chk(out_valid && out_char == prev_char, "R6", "stall hold",
            int'(out_char), int'(prev_char));
      if (stall_mode != 0) rdy = (wait_cnt >= 4);
      else rdy = ($urandom % 3) != 0;
      out_ready = rdy;
      if (out_valid) begin
        chk(!in_ready, "R6", "in_ready while char pending", int'(in_ready), 0);
        if (rdy) begin
          if (op < exp_q.size())
            chk(out_char == exp_q[op], "R4", {tag, " char"}, int'(out_char), int'(exp_q[op]));
          else
            chk(1'b0, "R5", {tag, " extra char"}, int'(out_char), -1);
          op++;
          wait_cnt = 0;
        end else wait_cnt++;
      end
      prev_hold = out_valid && !rdy;
      prev_char = out_char;
      if (!eos_taken) begin
        in_valid = ($urandom % 4) != 0;
        in_eos   = (ip == sbits.size());
        in_bit   = (ip < sbits.size()) ? sbits[ip] : 1'b0;
        if (in_valid && in_ready) begin
          if (in_eos) eos_taken = 1;
          else ip++;
        end
      end else begin
        in_valid = 1'b0; in_eos = 1'b0;
      end
    end
    in_valid = 1'b0; in_eos = 1'b0;
    chk(n_done == 1, "R5", {tag, " done seen"}, n_done, 1);
    chk(op == exp_q.size(), "R3", {tag, " char count"}, op, exp_q.size());
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (out_valid || done || in_ready) begin
        chk(1'b0, "R5", {tag, " activity after done"}, int'({out_valid, done, in_ready}), 0);
        break;
      end
    end
    total++;  // R5 quiet window counted once
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R8", "out_valid after reset", int'(out_valid), 0);
    chk(!done, "R8", "done after reset", int'(done), 0);
    chk(!in_ready, "R8", "in_ready after reset", int'(in_ready), 0);

    // directed tree: root branch(1,2); 1 leaf; 2 branch(3,4); 3,4 leaves
    n_nodes = 5;
    is_leaf[0] = 0; lchild[0] = 1; rchild[0] = 2; parent[0] = -1; depth[0] = 0;
    is_leaf[1] = 1; chr[1] = 8'h61; parent[1] = 0; side[1] = 0; depth[1] = 1;
    is_leaf[2] = 0; lchild[2] = 3; rchild[2] = 4; parent[2] = 0; side[2] = 1; depth[2] = 1;
    is_leaf[3] = 1; chr[3] = 8'h62; parent[3] = 2; side[3] = 0; depth[3] = 2;
    is_leaf[4] = 1; chr[4] = 8'h63; parent[4] = 2; side[4] = 1; depth[4] = 2;
    load_tree();  // R1 host writes
    repeat (4) @(negedge clk);
    chk(!in_ready, "R2", "idle before go", int'(in_ready), 0);
    sbits = '{0, 1, 0, 1, 1, 0};   // R3 left/right: a b c a
    exp_q = '{8'h61, 8'h62, 8'h63, 8'h61};
    run_stream("directed");

    stall_mode = 1;                 // R6 long stalls
    sbits = '{1, 1, 1, 0, 0};
    exp_q = '{8'h63, 8'h62, 8'h61};
    run_stream("stalled");
    stall_mode = 0;

    sbits = '{1};                   // R7 partial code then eos
    exp_q.delete();
    run_stream("partial");
    sbits.delete();                 // R5 empty stream
    run_stream("empty");

    for (int t = 0; t < 6; t++) begin   // R9 new trees after done
      random_tree(1 + ($urandom % 20), 8'h30 + 8'(t * 8));
      load_tree();
      make_stream(25 + ($urandom % 10), (t % 2) == 1);
      run_stream("random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule